// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing half of a 2048-byte serial memory. It watches the clock and data wires of a two-wire (I2C) bus by oversampling them with the system clock. It cleans up glitches on both wires and finds the START and STOP conditions. It moves bytes in and out MSB first, and it pulls the data wire low through an output enable when it acknowledges or sends a zero. The data wire is open drain: the pad drives low when `sdaOe` is high and floats otherwise.

A write command carries the three upper memory address bits. The byte after it carries the lower eight bits and loads the address counter. Each further byte is handed to a separate page-programming block as a one-cycle strobe with its address. A STOP after at least one such byte asks that block to start its erase/write cycle. While that block reports busy, every command is refused, so the master can poll until the slave acknowledges again.

The read command ignores its address bits and reads from the counter. The counter is either left over from earlier reads or just loaded by a write command that was cut short by a repeated START. Read data is fetched from a synchronous memory port one byte ahead. The counter steps after each fetch and wraps over the whole array.

Top module: `i2cEepromSlave`

## Requirements
- R1: After reset the data wire is released (`sdaOe` low), and `wrStrobe`, `wrCommit` and `rdEn` are all low.
- R2: A command byte whose bits 7..4 are 1010 is acknowledged by holding the data wire low during the ninth clock. A command with any other upper nibble is not acknowledged, and every later byte up to the next START is ignored: no acknowledge and no strobes.
- R3: While `progBusy` is high, neither a write command (bit 0 = 0) nor a read command (bit 0 = 1) is acknowledged.
- R4: In a write command, bits 3..1 become address bits 10..8. The next byte, which is acknowledged, becomes address bits 7..0.
- R5: Every byte after the address byte is acknowledged and shown on `wrByte`/`wrAddr` with a one-cycle `wrStrobe`. Successive bytes step only address bits 3..0, wrapping inside the same 16-byte page.
- R6: A STOP that follows at least one write data byte gives exactly one one-cycle `wrCommit`. A STOP after only an address byte, after a refused command or after a read gives none.
- R7: A repeated START after the address byte, followed by a read command, returns the byte at the loaded address. Bits 3..1 of the read command have no effect.
- R8: Read bytes leave the slave MSB first, and the slave releases the data wire during the acknowledge slot of each read byte.
- R9: A master acknowledge after a read byte makes the slave send the byte at the next address, wrapping from 0x7FF to 0x000. After a master non-acknowledge the slave leaves the data wire released until the next START.
- R10: A read command that is not preceded by an address write reads from the address just after the last byte read.
- R11: A pulse on the clock wire shorter than `FILT_LEN` system clocks is ignored and shifts no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock wire as seen at the pad |
| sdaIn | input | 1 | Bus data wire as seen at the pad |
| sdaOe | output | 1 | Pull the data wire low when high |
| progBusy | input | 1 | Page programming cycle in progress |
| wrByte | output | 8 | Write data byte for the page buffer |
| wrAddr | output | ADDR_W | Address of `wrByte` |
| wrStrobe | output | 1 | One-cycle valid for `wrByte`/`wrAddr` |
| wrCommit | output | 1 | One-cycle request to start programming |
| rdAddr | output | ADDR_W | Memory read address |
| rdEn | output | 1 | Memory read request; data expected one cycle later |
| rdData | input | 8 | Data from the synchronous memory port |

## Verification
A wrong address counter shows up as a wrong byte at the very next read, or as a wrong `wrAddr` on the first write strobe after a page boundary. A control phase that is off by one clock shows up within one byte as a missing acknowledge, or as a data wire that is still driven during an acknowledge slot. A lost page-pending flag shows up at the next STOP as a missing or extra `wrCommit`. Each random read goes through a repeated START with junk bits in the read command, so a decoding error is caught within a single transaction.

// File: rtl/i2cEepPkg.sv
package i2cEepPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_WDATA, S_RDATA, S_HALT
  } phase_t;

  typedef enum logic [1:0] {
    OE_KEEP, OE_ACK, OE_REL, OE_TX
  } oe_op_t;

  typedef struct packed {
    logic   shiftEn;
    logic   loadHi;
    logic   loadLo;
    logic   wrStb;
    logic   rdReq;
    logic   busRel;
    oe_op_t oeOp;
    logic [2:0] txBit;
  } strobe_t;

endpackage

// File: rtl/i2cEepFilter.sv
module i2cEepFilter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic fOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic s1, s2;
  logic [CNT_W-1:0] agreeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      fOut <= 1'b1;
      agreeCnt <= '0;
    end else begin
      s1 <= lineIn;
      s2 <= s1;
      if (s2 != fOut) begin
        if (agreeCnt == CNT_W'(FILT_LEN - 1)) begin
          fOut <= s2;
          agreeCnt <= '0;
        end else begin
          agreeCnt <= agreeCnt + 1'b1;
        end
      end else begin
        agreeCnt <= '0;
      end
    end
  end

  // The filtered level only ever moves to a level the synchronised line held
  p_filter_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fOut) |-> fOut == $past(s2));

endmodule

// File: rtl/i2cEepCtrl.sv
module i2cEepCtrl
  import i2cEepPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic       progBusy,
  input  logic [7:0] rxByte,
  output strobe_t    strb,
  output logic       wrCommit
);
  phase_t state, nState;
  logic [3:0] bitCnt, nCnt;
  logic sclP, sdaP, mAck, nMAck, wrPend, nWrPend;
  logic sclRise, sclFall, startEv, stopEv;

  assign sclRise = sclF & ~sclP;
  assign sclFall = ~sclF & sclP;
  assign startEv = sclF & sclP & sdaP & ~sdaF;
  assign stopEv  = sclF & sclP & ~sdaP & sdaF;

  always_comb begin
    strb = '0;
    nState = state;
    nCnt = bitCnt;
    nMAck = mAck;
    nWrPend = wrPend;
    wrCommit = 1'b0;
    if (startEv) begin
      nState = S_CMD;
      nCnt = '0;
      nWrPend = 1'b0;
      strb.busRel = 1'b1;
    end else if (stopEv) begin
      wrCommit = (state == S_WDATA) && wrPend;
      nState = S_IDLE;
      nWrPend = 1'b0;
      strb.busRel = 1'b1;
    end else if (state != S_IDLE && state != S_HALT) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) strb.shiftEn = 1'b1;
        if (bitCnt == 4'd8 && state == S_RDATA) begin
          nMAck = ~sdaF;
          strb.rdReq = ~sdaF;
        end
        if (bitCnt < 4'd9) nCnt = bitCnt + 4'd1;
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          case (state)
            S_CMD: begin
              if (rxByte[7:4] == 4'b1010 && !progBusy) begin
                strb.oeOp = OE_ACK;
                strb.rdReq = rxByte[0];
                strb.loadHi = ~rxByte[0];
              end else begin
                nState = S_HALT;
              end
            end
            S_ADDR: begin
              strb.oeOp = OE_ACK;
              strb.loadLo = 1'b1;
            end
            S_WDATA: begin
              strb.oeOp = OE_ACK;
              strb.wrStb = 1'b1;
              nWrPend = 1'b1;
            end
            default: strb.oeOp = OE_REL;
          endcase
        end else if (bitCnt == 4'd9) begin
          nCnt = '0;
          strb.oeOp = OE_REL;
          case (state)
            S_CMD: begin
              nState = rxByte[0] ? S_RDATA : S_ADDR;
              if (rxByte[0]) begin
                strb.oeOp = OE_TX;
                strb.txBit = 3'd7;
              end
            end
            S_ADDR: nState = S_WDATA;
            S_RDATA: begin
              if (mAck) begin
                strb.oeOp = OE_TX;
                strb.txBit = 3'd7;
              end else begin
                nState = S_HALT;
              end
            end
            default: ;
          endcase
        end else if (bitCnt != 4'd0 && state == S_RDATA) begin
          strb.oeOp = OE_TX;
          strb.txBit = 3'd7 - bitCnt[2:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      bitCnt <= '0;
      sclP <= 1'b1;
      sdaP <= 1'b1;
      mAck <= 1'b0;
      wrPend <= 1'b0;
    end else begin
      state <= nState;
      bitCnt <= nCnt;
      sclP <= sclF;
      sdaP <= sdaF;
      mAck <= nMAck;
      wrPend <= nWrPend;
    end
  end

  // R2: a refused or finished transaction stays silent until the next START
  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HALT) |-> (!strb.wrStb && !strb.rdReq && strb.oeOp == OE_KEEP));

  // R3: a command completed while programming is busy is refused
  p_busy_refuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && state == S_CMD && sclFall && bitCnt == 4'd8 && !startEv && !stopEv)
      |=> state == S_HALT);

  // R6: the commit request is a single pulse
  p_commit_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

endmodule

// File: rtl/i2cEepPath.sv
module i2cEepPath
  import i2cEepPkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DRV_DLY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              sdaF,
  input  logic [7:0]        rdData,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] addrCnt,
  output logic              sdaOe
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int DLY_W = $clog2(DRV_DLY + 1);

  logic [HI_W-1:0]  addrHi;
  logic [7:0]       txReg;
  logic             rdPend, drvPend;
  oe_op_t           pendOp;
  logic [2:0]       pendBit;
  logic [DLY_W-1:0] dlyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      addrHi <= '0;
      addrCnt <= '0;
      txReg <= '0;
      rdPend <= 1'b0;
    end else begin
      if (strb.shiftEn) rxByte <= {rxByte[6:0], sdaF};
      if (strb.loadHi) addrHi <= rxByte[HI_W:1];
      if (strb.loadLo) addrCnt <= {addrHi, rxByte};
      else if (strb.wrStb) addrCnt[3:0] <= addrCnt[3:0] + 4'd1;
      else if (strb.rdReq) addrCnt <= addrCnt + 1'b1;
      rdPend <= strb.rdReq;
      if (rdPend) txReg <= rdData;
    end
  end

  // Data-wire changes are held back a fixed number of clocks after the clock fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
      drvPend <= 1'b0;
      pendOp <= OE_KEEP;
      pendBit <= '0;
      dlyCnt <= '0;
    end else if (strb.busRel) begin
      sdaOe <= 1'b0;
      drvPend <= 1'b0;
    end else if (strb.oeOp != OE_KEEP) begin
      drvPend <= 1'b1;
      pendOp <= strb.oeOp;
      pendBit <= strb.txBit;
      dlyCnt <= DLY_W'(DRV_DLY - 1);
    end else if (drvPend) begin
      if (dlyCnt == '0) begin
        drvPend <= 1'b0;
        case (pendOp)
          OE_ACK:  sdaOe <= 1'b1;
          OE_TX:   sdaOe <= ~txReg[pendBit];
          default: sdaOe <= 1'b0;
        endcase
      end else begin
        dlyCnt <= dlyCnt - 1'b1;
      end
    end
  end

  // R5: page writes never move the page part of the address
  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && !strb.loadLo) |=> $stable(addrCnt[ADDR_W-1:4]));

endmodule

// File: rtl/i2cEepromSlave.sv
module i2cEepromSlave
  import i2cEepPkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int FILT_LEN = 3,
  parameter int DRV_DLY  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              progBusy,
  output logic [7:0]        wrByte,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrStrobe,
  output logic              wrCommit,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdEn,
  input  logic [7:0]        rdData
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines, fLines;
  strobe_t strb;
  logic [7:0] rxByte;
  logic [ADDR_W-1:0] addrCnt;

  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < N_LINES; i++) begin : g_filt
    i2cEepFilter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .lineIn(rawLines[i]), .fOut(fLines[i])
    );
  end

  i2cEepCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(fLines[0]), .sdaF(fLines[1]),
    .progBusy(progBusy), .rxByte(rxByte), .strb(strb), .wrCommit(wrCommit)
  );

  i2cEepPath #(.ADDR_W(ADDR_W), .DRV_DLY(DRV_DLY)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaF(fLines[1]), .rdData(rdData),
    .rxByte(rxByte), .addrCnt(addrCnt), .sdaOe(sdaOe)
  );

  assign wrByte   = rxByte;
  assign wrAddr   = addrCnt;
  assign wrStrobe = strb.wrStb;
  assign rdAddr   = addrCnt;
  assign rdEn     = strb.rdReq;

endmodule

// File: tb/sim_i2cEepromSlave.sv
module sim_i2cEepromSlave;
  localparam int CLK_P = 10;
  localparam int Q = 16;
  localparam int N_VEC = 5;
  // {address, expected byte}; memory model byte = addr[7:0] ^ addr[10:8]
  localparam logic [18:0] RD_VEC [N_VEC] = '{
    {11'h000, 8'h00}, {11'h123, 8'h22}, {11'h7FF, 8'hF8},
    {11'h456, 8'h52}, {11'h2AB, 8'hA9}
  };

  logic clk = 0, rstN = 0;
  logic mScl = 1, mSda = 1, progBusy = 0;
  logic sdaOe, wrStrobe, wrCommit, rdEn;
  logic [7:0] wrByte, rdData;
  logic [10:0] wrAddr, rdAddr;
  logic sdaLine;
  int nChk = 0, nBad = 0, wN = 0, cN = 0;
  logic [18:0] wLog [32];
  bit done = 0;

  assign sdaLine = mSda & ~sdaOe;
  always #(CLK_P/2) clk = ~clk;

  i2cEepromSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .progBusy(progBusy), .wrByte(wrByte), .wrAddr(wrAddr), .wrStrobe(wrStrobe),
    .wrCommit(wrCommit), .rdAddr(rdAddr), .rdEn(rdEn), .rdData(rdData)
  );

  function automatic logic [7:0] memFn(input logic [10:0] a);
    return a[7:0] ^ {5'b0, a[10:8]};
  endfunction

  always @(posedge clk) begin
    if (rdEn) rdData <= memFn(rdAddr);
    if (wrStrobe && wN < 32) begin wLog[wN] <= {wrAddr, wrByte}; wN <= wN + 1; end
    if (wrCommit) cN <= cN + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sStart;
    mSda = 1; tick(Q); mScl = 1; tick(2*Q); mSda = 0; tick(2*Q); mScl = 0; tick(Q);
  endtask

  task automatic sStop;
    mSda = 0; tick(Q); mScl = 1; tick(2*Q); mSda = 1; tick(2*Q);
  endtask

  task automatic sendBit(input logic b, output logic s);
    mSda = b; tick(Q); mScl = 1; tick(Q); s = sdaLine; tick(Q); mScl = 0; tick(Q);
  endtask

  task automatic xferByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(b[i], s);
    sendBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v, output logic rel);
    logic s;
    for (int i = 0; i < 8; i++) begin sendBit(1'b1, s); v = {v[6:0], s}; end
    sendBit(~giveAck, s);
    rel = s;
  endtask

  task automatic setAddr(input logic [10:0] a, output logic ackC, output logic ackA);
    sStart;
    xferByte({4'b1010, a[10:8], 1'b0}, ackC);
    xferByte(a[7:0], ackA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic a1, a2, rel;
    logic [7:0] v;
    int w0, c0;
    tick(5);
    rstN = 1;
    tick(10);
    // R1: reset state
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 strobes", {wrStrobe, wrCommit, rdEn}, 0);

    // R2 R4 R5 R6: page write across a page boundary
    setAddr(11'h53E, a1, a2);
    chk("R2 write cmd ack", a1, 1);
    chk("R4 addr ack", a2, 1);
    xferByte(8'h11, a1); chk("R5 data ack", a1, 1);
    xferByte(8'h22, a1);
    xferByte(8'h33, a1);
    xferByte(8'h44, a1); chk("R5 data ack last", a1, 1);
    sStop; tick(4);
    chk("R5 strobe count", wN, 4);
    chk("R5 byte0", wLog[0], {11'h53E, 8'h11});
    chk("R5 byte1", wLog[1], {11'h53F, 8'h22});
    chk("R5 page wrap", wLog[2], {11'h530, 8'h33});
    chk("R5 byte3", wLog[3], {11'h531, 8'h44});
    chk("R6 one commit", cN, 1);

    // R3: busy refuses both commands
    progBusy = 1;
    sStart; xferByte(8'hA0, a1); chk("R3 write cmd nack", a1, 0); sStop;
    sStart; xferByte(8'hA1, a1); chk("R3 read cmd nack", a1, 0); sStop;
    progBusy = 0; tick(4);
    chk("R3 no strobes", wN, 4);
    chk("R6 no commit when refused", cN, 1);

    // R2: wrong upper nibble, later bytes ignored
    sStart; xferByte(8'hB0, a1); chk("R2 bad nibble nack", a1, 0);
    xferByte(8'h00, a1); chk("R2 later byte ignored", a1, 0);
    xferByte(8'h5A, a1); sStop; tick(4);
    chk("R2 no strobe after nack", wN, 4);

    // R6: address only then stop
    setAddr(11'h010, a1, a2); sStop; tick(4);
    chk("R6 no commit after address only", cN, 1);

    // R7 R8: random reads from the vector table with junk read bits
    for (int k = 0; k < N_VEC; k++) begin
      setAddr(RD_VEC[k][18:8], a1, a2);
      sStart; xferByte(8'hAF - 8'(2 * (k % 4)), a1);
      chk("R7 read cmd ack", a1, 1);
      readByte(1'b0, v, rel);
      chk("R7 random read data", v, RD_VEC[k][7:0]);
      chk("R8 released in ack slot", rel, 1);
      sStop;
    end
    tick(4);
    chk("R6 no commit after reads", cN, 1);

    // R9: sequential read wraps the top of memory
    setAddr(11'h7FE, a1, a2);
    sStart; xferByte(8'hA1, a1);
    readByte(1'b1, v, rel); chk("R9 seq byte0", v, 8'hF9);
    readByte(1'b1, v, rel); chk("R9 seq byte1", v, 8'hF8);
    readByte(1'b0, v, rel); chk("R9 seq wrap to 0", v, 8'h00);
    mSda = 1; tick(6*Q);
    chk("R9 released after nack", sdaOe, 0);
    sStop;

    // R10: current-address read
    sStart; xferByte(8'hA1, a1);
    readByte(1'b0, v, rel); chk("R10 current address", v, 8'h01);
    sStop;

    // R11: short clock glitch during a write
    w0 = wN; c0 = cN;
    setAddr(11'h105, a1, a2);
    mSda = 1; tick(Q); mScl = 1; tick(1); mScl = 0; tick(Q);
    xferByte(8'h5A, a1);
    chk("R11 ack after glitch", a1, 1);
    sStop; tick(4);
    chk("R11 one byte", wN - w0, 1);
    chk("R11 data intact", wLog[w0], {11'h105, 8'h5A});
    chk("R6 commit after glitch write", cN - c0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule